// File: doc/BRIEF.md
# Top-Three AC Coefficient Watermark Inserter

This block takes one block of transform-domain coefficients at a time and embeds a pseudo-random watermark in it. Each block arrives as a stream. The first coefficient is the DC term and the rest are AC terms. While the block streams in, the inserter keeps a running ranking of the AC terms with the largest magnitudes. Once the block is complete, the three top-ranked terms are known.

The whole block sits in an internal buffer. After the final coefficient is taken in, the block streams back out in its original order. The three selected AC terms are changed by an amount proportional to the coefficient itself, a strength value and a signed 8-bit number drawn from an internal 16-bit LFSR. All other coefficients, the DC term included, leave the block untouched.

While a block is being emitted the inserter does not accept input, and it signals this on a ready output. The transform itself, quantisation and watermark detection are handled elsewhere.

Top module: `wm_top3_insert`

## Requirements
- R1: After a clocked reset with `rst_n` low, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: A coefficient is accepted on a clock edge where `in_valid` and `in_ready` are both 1. The first accepted coefficient of a block has index 0. A block ends at the accepted coefficient that has `in_last` high, or at index BLK_LEN-1 (63), whichever comes first. Call the edge that accepts the ending coefficient E0. `in_ready` is 0 from E0 until output index L-1 has been presented, where L is the block length. Output index k appears at edge E0+1+k, one coefficient per cycle in arrival order. `out_last` is 1 only with index L-1.
- R3: The AC coefficients of a block are the indices 1 to L-1. Up to three of them are selected, ranked by absolute value. When two magnitudes are equal, the coefficient with the lower index ranks higher.
- R4: The DC coefficient (index 0) and every AC coefficient that is not selected are output bit-for-bit unchanged.
- R5: A selected coefficient c becomes c + ((c * a * w) >>> 8). Here a is the unsigned 8-bit strength, w is the signed watermark value, and >>> is an arithmetic shift that rounds toward minus infinity. The result saturates to the 12-bit two's-complement range [-2048, 2047].
- R6: w is bits [7:0] of the 16-bit LFSR state, read as two's complement. Reset loads the state 0xACE1. The LFSR steps once for each selected coefficient, in output order. One step is: shift the state right by one, then XOR with 0xB400 if the bit shifted out was 1. The state carries over from block to block.
- R7: The strength `alpha` is sampled at edge E0. Changes to `alpha` during output do not affect the block being emitted.
- R8: A block with fewer than three AC coefficients has every one of its AC coefficients selected. A block of length 1 passes through unchanged and does not step the LFSR.
- R9: `in_valid` and `in_coef` are ignored while `in_ready` is 0. Neither the block being emitted nor the contents of the next block are affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input coefficient valid |
| in_coef | input | 12 | Input coefficient, two's complement |
| in_last | input | 1 | Marks the final coefficient of a block |
| alpha | input | 8 | Watermark strength, unsigned |
| in_ready | output | 1 | Block can accept a coefficient |
| out_valid | output | 1 | Output coefficient valid |
| out_coef | output | 12 | Output coefficient, two's complement |
| out_last | output | 1 | Final coefficient of the output block |

## Verification
Every output coefficient has a fixed due cycle: index k of a block is due exactly 1+k edges after the edge that took in the block's ending coefficient. On the cycle between that edge and the first output, ready and valid must both be low. The bench feeds inputs on falling edges and compares each output on the falling edge just after its due rising edge. It checks value, valid and last flag against a reference built arithmetically from the requirements, and it keeps its own copy of the LFSR sequence across blocks. One falling edge after the last coefficient, the bench checks that valid has dropped and ready has risen. The next block starts from that point, so any input the design took early or an output it sent late shows up as a mismatch.

// File: rtl/wm_pkg.sv
// Package: shared types for the watermark inserter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package wm_pkg;

    // Two phases: gather a block, then emit it.
    typedef enum logic {
        ST_COLLECT = 1'b0,
        ST_EMIT    = 1'b1
    } wm_state_e;

endpackage

// File: rtl/wm_lfsr.sv
// Galois LFSR that supplies the watermark sequence.
// Reset loads SEED; the state advances only when adv is high.
// Assumes SEED is nonzero, so the state never becomes all zeros.
module wm_lfsr #(
    parameter int                 LFSR_W = 16,
    parameter logic [LFSR_W-1:0]  MASK   = 16'hB400,
    parameter logic [LFSR_W-1:0]  SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] nxt;

    // One Galois step: shift right and fold the mask in when the bit shifted out is 1.
    always_comb begin
        nxt = {1'b0, state[LFSR_W-1:1]} ^ (state[0] ? MASK : '0);
    end

    // State register: seed on reset, step on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (adv) begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/wm_top3_tracker.sv
// Keeps the NUM_MARK largest-magnitude AC coefficients of the block being
// received, sorted from largest down. On a strictly larger magnitude the new
// entry takes the slot and pushes the rest down, so the earlier arrival wins a tie.
// Assumes index 0 of every block is the DC term: accepting it clears the list,
// and it is never entered.
module wm_top3_tracker #(
    parameter int COEF_W   = 12,
    parameter int IDX_W    = 6,
    parameter int NUM_MARK = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     upd,
    input  logic                     first,
    input  logic signed [COEF_W-1:0] cand_coef,
    input  logic [IDX_W-1:0]         cand_idx,
    input  logic [IDX_W-1:0]         query_idx,
    output logic                     query_hit
);

    logic [COEF_W-1:0]   cand_mag;
    logic [NUM_MARK-1:0] vld_q, vld_d, gt, hit_vec;
    logic [COEF_W-1:0]   mag_q [NUM_MARK];
    logic [COEF_W-1:0]   mag_d [NUM_MARK];
    logic [IDX_W-1:0]    idx_q [NUM_MARK];
    logic [IDX_W-1:0]    idx_d [NUM_MARK];

    // Absolute value; the most negative code still fits as an unsigned value.
    always_comb begin
        cand_mag = cand_coef[COEF_W-1] ? COEF_W'(-cand_coef) : COEF_W'(cand_coef);
    end

    for (genvar k = 0; k < NUM_MARK; k++) begin : g_slot
        // The candidate beats an empty slot or a strictly smaller magnitude.
        assign gt[k]      = !vld_q[k] || (cand_mag > mag_q[k]);
        assign hit_vec[k] = vld_q[k] && (idx_q[k] == query_idx);
        if (k == 0) begin : g_head
            assign vld_d[k] = gt[k] ? 1'b1     : vld_q[k];
            assign mag_d[k] = gt[k] ? cand_mag : mag_q[k];
            assign idx_d[k] = gt[k] ? cand_idx : idx_q[k];
        end else begin : g_tail
            // Inserted above: shift down. Inserted here: take the candidate.
            assign vld_d[k] = gt[k-1] ? vld_q[k-1] : (gt[k] ? 1'b1     : vld_q[k]);
            assign mag_d[k] = gt[k-1] ? mag_q[k-1] : (gt[k] ? cand_mag : mag_q[k]);
            assign idx_d[k] = gt[k-1] ? idx_q[k-1] : (gt[k] ? cand_idx : idx_q[k]);
        end
    end

    assign query_hit = |hit_vec;

    // Slot registers: clear on reset and on the DC term, insert on each AC term.
    always_ff @(posedge clk) begin
        if (!rst_n || (upd && first)) begin
            vld_q <= '0;
            for (int k = 0; k < NUM_MARK; k++) begin
                mag_q[k] <= '0;
                idx_q[k] <= '0;
            end
        end else if (upd) begin
            vld_q <= vld_d;
            for (int k = 0; k < NUM_MARK; k++) begin
                mag_q[k] <= mag_d[k];
                idx_q[k] <= idx_d[k];
            end
        end
    end

endmodule

// File: rtl/wm_mark_arith.sv
// Combinational marking: c + ((c * alpha * w) >>> SHIFT), saturated to COEF_W bits.
// Assumes alpha is unsigned and wm is two's complement.
module wm_mark_arith #(
    parameter int COEF_W  = 12,
    parameter int ALPHA_W = 8,
    parameter int WM_W    = 8,
    parameter int SHIFT   = 8
) (
    input  logic signed [COEF_W-1:0] coef,
    input  logic [ALPHA_W-1:0]       alpha,
    input  logic signed [WM_W-1:0]   wm,
    output logic signed [COEF_W-1:0] marked
);

    localparam int PW = COEF_W + ALPHA_W + WM_W + 2;
    localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (COEF_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

    logic signed [PW-1:0] c_x, a_x, w_x, prod, sum;

    // Widen every operand so the triple product cannot wrap.
    always_comb begin
        c_x  = PW'(coef);
        a_x  = PW'($signed({1'b0, alpha}));
        w_x  = PW'(wm);
        prod = c_x * a_x * w_x;
        sum  = c_x + (prod >>> SHIFT);
    end

    // Clamp to the output range.
    always_comb begin
        if (sum > MAXV) begin
            marked = MAXV[COEF_W-1:0];
        end else if (sum < MINV) begin
            marked = MINV[COEF_W-1:0];
        end else begin
            marked = sum[COEF_W-1:0];
        end
    end

endmodule

// File: rtl/wm_top3_insert.sv
// Top-three AC watermark inserter. Buffers a whole coefficient block while the
// top-magnitude AC terms are ranked, then replays the block in order and marks
// the selected terms with LFSR values scaled by a strength sampled at block end.
// Assumes input stalls are signalled only through in_ready; no output back-pressure.
module wm_top3_insert #(
    parameter int                COEF_W    = 12,
    parameter int                ALPHA_W   = 8,
    parameter int                WM_W      = 8,
    parameter int                SHIFT     = 8,
    parameter int                BLK_LEN   = 64,
    parameter int                NUM_MARK  = 3,
    parameter int                LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_MASK = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [COEF_W-1:0] in_coef,
    input  logic                     in_last,
    input  logic [ALPHA_W-1:0]       alpha,
    output logic                     in_ready,
    output logic                     out_valid,
    output logic signed [COEF_W-1:0] out_coef,
    output logic                     out_last
);

    import wm_pkg::*;

    localparam int               IDX_W   = $clog2(BLK_LEN);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(BLK_LEN - 1);

    wm_state_e                state_q;
    logic [IDX_W-1:0]         wr_idx_q, rd_idx_q, last_idx_q;
    logic [ALPHA_W-1:0]       alpha_q;
    logic signed [COEF_W-1:0] coef_mem [BLK_LEN];
    logic signed [COEF_W-1:0] rd_coef, marked;
    logic                     accept, blk_end, emitting, hit, mark_adv;
    logic [LFSR_W-1:0]        lfsr_q;

    assign in_ready = (state_q == ST_COLLECT);
    assign accept   = in_valid && in_ready;
    assign blk_end  = accept && (in_last || (wr_idx_q == IDX_MAX));
    assign emitting = (state_q == ST_EMIT);
    assign rd_coef  = coef_mem[rd_idx_q];
    assign mark_adv = emitting && hit;

    // Block buffer: write-only while collecting, read while emitting.
    always_ff @(posedge clk) begin
        if (accept) begin
            coef_mem[wr_idx_q] <= in_coef;
        end
    end

    // Phase control, write/read indices and strength capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_COLLECT;
            wr_idx_q   <= '0;
            rd_idx_q   <= '0;
            last_idx_q <= '0;
            alpha_q    <= '0;
        end else if (state_q == ST_COLLECT) begin
            if (accept) begin
                wr_idx_q <= blk_end ? '0 : wr_idx_q + 1'b1;
            end
            if (blk_end) begin
                last_idx_q <= wr_idx_q;
                alpha_q    <= alpha;
                rd_idx_q   <= '0;
                state_q    <= ST_EMIT;
            end
        end else begin
            rd_idx_q <= rd_idx_q + 1'b1;
            if (rd_idx_q == last_idx_q) begin
                state_q <= ST_COLLECT;
            end
        end
    end

    // Output register: marked or original coefficient, with framing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_coef  <= '0;
        end else begin
            out_valid <= emitting;
            out_last  <= emitting && (rd_idx_q == last_idx_q);
            out_coef  <= hit ? marked : rd_coef;
        end
    end

    wm_top3_tracker #(
        .COEF_W   (COEF_W),
        .IDX_W    (IDX_W),
        .NUM_MARK (NUM_MARK)
    ) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (accept),
        .first     (wr_idx_q == '0),
        .cand_coef (in_coef),
        .cand_idx  (wr_idx_q),
        .query_idx (rd_idx_q),
        .query_hit (hit)
    );

    wm_lfsr #(
        .LFSR_W (LFSR_W),
        .MASK   (LFSR_MASK),
        .SEED   (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (mark_adv),
        .state (lfsr_q)
    );

    wm_mark_arith #(
        .COEF_W  (COEF_W),
        .ALPHA_W (ALPHA_W),
        .WM_W    (WM_W),
        .SHIFT   (SHIFT)
    ) u_arith (
        .coef   (rd_coef),
        .alpha  (alpha_q),
        .wm     ($signed(lfsr_q[WM_W-1:0])),
        .marked (marked)
    );

endmodule

// File: rtl/wm_top3_insert_chk.sv
// Checker for the inserter: framing, marking budget and LFSR stepping.
// Attached to every wm_top3_insert instance by the bind at the end of this file.
module wm_top3_insert_chk #(
    parameter int IDX_W    = 6,
    parameter int NUM_MARK = 3,
    parameter int LFSR_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_last,
    input logic              emitting,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              mark_adv,
    input logic [LFSR_W-1:0] lfsr_q
);

    logic [IDX_W:0] mark_cnt;

    // Marks issued so far in the block being emitted.
    always_ff @(posedge clk) begin
        if (!rst_n || !emitting) begin
            mark_cnt <= '0;
        end else if (mark_adv) begin
            mark_cnt <= mark_cnt + 1'b1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_last && in_ready)); // R1

    AST_NO_INPUT_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> !in_ready); // R2

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R2

    AST_MARK_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        emitting |-> ((mark_cnt + IDX_W'(mark_adv)) <= NUM_MARK)); // R3

    AST_DC_UNMARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (emitting && (rd_idx == '0)) |-> !mark_adv); // R4

    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mark_adv |=> $stable(lfsr_q)); // R6

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R6

endmodule

bind wm_top3_insert wm_top3_insert_chk #(
    .IDX_W    (IDX_W),
    .NUM_MARK (NUM_MARK),
    .LFSR_W   (LFSR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .emitting  (emitting),
    .rd_idx    (rd_idx_q),
    .mark_adv  (mark_adv),
    .lfsr_q    (lfsr_q)
);

// File: tb/test_wm_top3_insert.sv
// Self-checking bench: sweeps many blocks, recomputing the expected output
// from the written rules with its own ranking and LFSR model.
module test_wm_top3_insert;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [11:0] in_coef = '0;
    logic              in_last = 1'b0;
    logic [7:0]        alpha = '0;
    logic              in_ready, out_valid, out_last;
    logic signed [11:0] out_coef;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    int stim [64];
    int expv [64];
    int model_lfsr = 'hACE1;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    wm_top3_insert i_wm_top3_insert (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_coef   (in_coef),
        .in_last   (in_last),
        .alpha     (alpha),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_coef  (out_coef),
        .out_last  (out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int span);
        rng = rng * 32'd1103515245 + 32'd12345;
        return int'(rng[30:16]) % span;
    endfunction

    // Expected block: rank AC magnitudes (earlier wins ties), then mark in index order.
    task automatic build_expect(input int len, input int a);
        int sel_idx [3];
        int sel_mag [3];
        int n = 0;
        for (int i = 1; i < len; i++) begin
            int m = (stim[i] < 0) ? -stim[i] : stim[i];
            int p = (n < 3) ? n : 3;
            for (int j = n - 1; j >= 0; j--) begin
                if (m > sel_mag[j]) p = j;
            end
            if (p < 3) begin
                for (int j = ((n < 3) ? n : 2); j > p; j--) begin
                    sel_idx[j] = sel_idx[j-1];
                    sel_mag[j] = sel_mag[j-1];
                end
                sel_idx[p] = i;
                sel_mag[p] = m;
                if (n < 3) n++;
            end
        end
        for (int i = 0; i < len; i++) begin
            bit pick = 1'b0;
            for (int j = 0; j < n; j++) if (sel_idx[j] == i) pick = 1'b1;
            expv[i] = stim[i];
            if (pick) begin
                int w = model_lfsr & 255;
                int v;
                if (w > 127) w -= 256;
                v = stim[i] + ((stim[i] * a * w) >>> 8);
                if (v > 2047) v = 2047;
                if (v < -2048) v = -2048;
                expv[i] = v;
                model_lfsr = (model_lfsr & 1) ? ((model_lfsr >> 1) ^ 'hB400) : (model_lfsr >> 1);
            end
        end
    endtask

    // Drive one block, then check every output at its due cycle.
    task automatic run_block(input int len, input int a, input bit use_last, input bit disturb);
        build_expect(len, a);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            check(in_ready == 1'b1, "R2 ready while collecting", int'(in_ready), 1);
            in_valid = 1'b1;
            in_coef  = 12'(stim[i]);
            in_last  = use_last && (i == len - 1);
            alpha    = 8'(a);
        end
        @(negedge clk);
        in_valid = disturb;
        in_last  = 1'b0;
        in_coef  = 12'sd2047;
        if (disturb) alpha = 8'(a ^ 8'h5A); // R7: strength changes after sampling
        check(!in_ready && !out_valid, "R2 gap cycle", int'({in_ready, out_valid}), 0);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            check(out_valid == 1'b1, "R2 out_valid", int'(out_valid), 1);
            check(int'(out_coef) == expv[k], "R5 R3 R4 coefficient", int'(out_coef), expv[k]);
            check(out_last == (k == len - 1), "R2 out_last", int'(out_last), int'(k == len - 1));
            in_valid = disturb && (k < len - 1); // R9: ignored while not ready
            in_coef  = 12'(-2048 + k);
        end
        @(negedge clk);
        check(!out_valid && in_ready, "R2 block done", int'({out_valid, in_ready}), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_last && in_ready, "R1 reset state",
              int'({out_valid, out_last, in_ready}), 1);

        // R3 R5 R6: random full blocks over a sweep of strengths.
        for (int b = 0; b < 40; b++) begin
            for (int i = 0; i < 64; i++) stim[i] = rnd(4096) - 2048;
            run_block(64, (b * 37) % 256, b[0], 1'b0);
        end
        // R3: equal magnitudes, earliest three win.
        for (int i = 0; i < 64; i++) stim[i] = (i % 2) ? -9 : 9;
        run_block(64, 200, 1'b1, 1'b0);
        // R3: ties among the largest, with mixed signs.
        for (int i = 0; i < 64; i++) stim[i] = i % 5;
        stim[0] = 1500; stim[40] = -300; stim[10] = 300; stim[20] = 300; stim[5] = -299;
        run_block(64, 128, 1'b0, 1'b0);
        // R5: saturation at both extremes.
        for (int b = 0; b < 4; b++) begin
            for (int i = 0; i < 64; i++) stim[i] = (i % 3 == 0) ? 2047 : ((i % 3 == 1) ? -2048 : 0);
            run_block(64, 255, 1'b1, 1'b0);
        end
        // R8: short blocks.
        stim[0] = 77; stim[1] = -3; stim[2] = 1000;
        run_block(3, 90, 1'b1, 1'b0);
        stim[0] = -1234;
        run_block(1, 255, 1'b1, 1'b0);
        stim[0] = 5; stim[1] = 6; stim[2] = 7; stim[3] = 8; stim[4] = 1;
        run_block(5, 60, 1'b1, 1'b0);
        // R7 R9: strength changes and stray input during output.
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < 64; i++) stim[i] = rnd(1024) - 512;
            run_block(64, 150 + b, 1'b1, 1'b1);
        end
        // R9: block right after disturbed one must be clean.
        for (int i = 0; i < 64; i++) stim[i] = rnd(200) - 100;
        run_block(64, 33, 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule